// File: doc/BRIEF.md
# SHA-1 Four-Round Step Engine

This block advances a SHA-1 working state by four compression rounds. It takes a 128-bit state word holding A, B, C and D, a 128-bit group of four message words in which the caller has already added the incoming E value to the first word, and a selector. The selector picks one round function and one round constant, and that choice applies to all four rounds.

The engine works iteratively and computes one round per clock. A `start` pulse while the engine is idle captures all operands. Four cycles later `done` pulses for one cycle, and the updated state appears on `abcd_out`. That value stays on the output until the next accepted start. Message scheduling, E folding for later groups, padding and the final hash addition all happen outside this block.

Top module: `sha1_rounds4`

## Requirements
- R1: The state is packed with A in bits [127:96], B in [95:64], C in [63:32] and D in [31:0]. `abcd_out` uses the same packing.
- R2: Round 0 uses message bits [127:96], round 1 uses [95:64], round 2 uses [63:32] and round 3 uses [31:0].
- R3: Selector code 0 gives f=(B&C)|(~B&D) with K=0x5A827999. Code 1 gives f=B^C^D with K=0x6ED9EBA1. Code 2 gives f=majority(B,C,D) with K=0x8F1BBCDC. Code 3 gives f=B^C^D with K=0xCA62C1D6.
- R4: Each round forms T = f(B,C,D) + (A rotated left by 5) + W + K + E, with every addition taken modulo 2^32. E is zero in round 0 and equals the previous D in each later round.
- R5: After each round the new values are A=T, B=old A, C=old B rotated left by 30, D=old C and E=old D.
- R6: Only selector bits [1:0] affect the result. Any higher selector bits are ignored.
- R7: A `start` seen while `busy` is low captures the state, message and selector and raises `busy`. A `start` seen while `busy` is high has no effect on the result.
- R8: `done` is high for exactly one cycle. It rises on the fourth clock edge after the edge that accepted the start, and `busy` falls at that same edge.
- R9: While the engine is idle, `abcd_out` holds its value until the next accepted start.
- R10: A synchronous active-high `rst` clears `busy`, `done` and the round counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request; accepted only when idle |
| abcd_in | input | 128 | Working state A..D, A in the top word |
| msg_in | input | 128 | Four message words, first word on top, E pre-added |
| sel_in | input | SEL_W | Round selector; only bits [1:0] are used |
| busy | output | 1 | High while rounds are in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| abcd_out | output | 128 | Updated state A..D, A in the top word |

## Verification
The bench builds the engine with SEL_W=4, which makes the ignored upper selector bits reachable. It applies all sixteen selector codes to each of eight operand sets, so every function and constant is checked both with and without extra high bits set. Fixed all-zero and all-one operands exercise the carry and wraparound cases. Separate runs cover a start raised while the engine is busy, a reset in the middle of a run, and holding of the result across idle cycles.

// File: rtl/sha1r_pkg.sv
package sha1r_pkg;
    localparam int WORD_W  = 32;
    localparam int LANES   = 4;
    localparam int STATE_W = WORD_W * LANES;
    localparam int ROUNDS  = 4;
    localparam int CNT_W   = $clog2(ROUNDS);
    localparam int FSEL_W  = 2;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic               busy;
        logic               done;
        logic [CNT_W-1:0]   cnt;
        logic [FSEL_W-1:0]  fsel;
        word_t              a;
        word_t              b;
        word_t              c;
        word_t              d;
        word_t              e;
        logic [STATE_W-1:0] msg;
    } eng_regs_t;

    function automatic word_t rotl(word_t x, int unsigned n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction
endpackage

// File: rtl/sha1r_boolfn.sv
module sha1r_boolfn
    import sha1r_pkg::*;
(
    input  logic [FSEL_W-1:0] fsel,
    input  word_t             b,
    input  word_t             c,
    input  word_t             d,
    output word_t             f,
    output word_t             k
);
    always_comb begin
        unique case (fsel)
            2'd0: begin
                f = (b & c) | (~b & d);
                k = 32'h5A82_7999;
            end
            2'd1: begin
                f = b ^ c ^ d;
                k = 32'h6ED9_EBA1;
            end
            2'd2: begin
                f = (b & c) | (b & d) | (c & d);
                k = 32'h8F1B_BCDC;
            end
            default: begin
                f = b ^ c ^ d;
                k = 32'hCA62_C1D6;
            end
        endcase
    end
endmodule

// File: rtl/sha1r_round.sv
module sha1r_round
    import sha1r_pkg::*;
(
    input  logic [FSEL_W-1:0] fsel,
    input  word_t             a,
    input  word_t             b,
    input  word_t             c,
    input  word_t             d,
    input  word_t             e,
    input  word_t             w,
    output word_t             t
);
    word_t f_val;
    word_t k_val;

    sha1r_boolfn u_fn (
        .fsel (fsel),
        .b    (b),
        .c    (c),
        .d    (d),
        .f    (f_val),
        .k    (k_val)
    );

    assign t = f_val + rotl(a, 5) + w + k_val + e;
endmodule

// File: rtl/sha1_rounds4.sv
module sha1_rounds4
    import sha1r_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [STATE_W-1:0] abcd_in,
    input  logic [STATE_W-1:0] msg_in,
    input  logic [SEL_W-1:0]   sel_in,
    output logic               busy,
    output logic               done,
    output logic [STATE_W-1:0] abcd_out
);
    localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(ROUNDS - 1);

    eng_regs_t q_q;
    eng_regs_t q_d;
    word_t     in_w [LANES];
    word_t     w_cur;
    word_t     t_val;
    logic [CNT_W-1:0] round_cnt;

    // Lane g occupies bits [32g+31:32g]; lane 3 carries A.
    for (genvar g = 0; g < LANES; g++) begin : g_unpack
        assign in_w[g] = abcd_in[g*WORD_W +: WORD_W];
    end

    // Message group shifts up each round, so the top word is always current.
    assign w_cur = q_q.msg[STATE_W-1 -: WORD_W];

    sha1r_round u_round (
        .fsel (q_q.fsel),
        .a    (q_q.a),
        .b    (q_q.b),
        .c    (q_q.c),
        .d    (q_q.d),
        .e    (q_q.e),
        .w    (w_cur),
        .t    (t_val)
    );

    always_comb begin
        q_d      = q_q;
        q_d.done = 1'b0;
        if (q_q.busy) begin
            q_d.a   = t_val;
            q_d.b   = q_q.a;
            q_d.c   = rotl(q_q.b, 30);
            q_d.d   = q_q.c;
            q_d.e   = q_q.d;
            q_d.msg = q_q.msg << WORD_W;
            q_d.cnt = q_q.cnt + 1'b1;
            if (q_q.cnt == LAST_RND) begin
                q_d.busy = 1'b0;
                q_d.done = 1'b1;
            end
        end else if (start) begin
            q_d.a    = in_w[3];
            q_d.b    = in_w[2];
            q_d.c    = in_w[1];
            q_d.d    = in_w[0];
            q_d.e    = '0;
            q_d.msg  = msg_in;
            q_d.fsel = sel_in[FSEL_W-1:0];
            q_d.cnt  = '0;
            q_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_q.busy <= 1'b0;
            q_q.done <= 1'b0;
            q_q.cnt  <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign busy      = q_q.busy;
    assign done      = q_q.done;
    assign round_cnt = q_q.cnt;
    assign abcd_out  = {q_q.a, q_q.b, q_q.c, q_q.d};
endmodule

// File: rtl/sha1r_chk.sv
module sha1r_chk
    import sha1r_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic [CNT_W-1:0]   cnt,
    input logic [STATE_W-1:0] abcd_out
);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(ROUNDS - 1);

    p_accept_r7: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && cnt == '0));

    p_advance_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != LAST_C) |=> (busy && cnt == CNT_W'($past(cnt) + 1'b1)));

    p_finish_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt == LAST_C) |=> (done && !busy));

    p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(abcd_out));

    p_clear_r10: assert property (@(posedge clk)
        rst |=> (!busy && !done && cnt == '0));
endmodule

bind sha1_rounds4 sha1r_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .cnt      (round_cnt),
    .abcd_out (abcd_out)
);

// File: tb/sha1_rounds4_test.sv
module sha1_rounds4_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [127:0] abcd_in = '0;
    logic [127:0] msg_in = '0;
    logic [3:0]   sel_in = '0;
    logic         busy;
    logic         done;
    logic [127:0] abcd_out;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  ended = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #2.5 clk = ~clk;

    sha1_rounds4 #(.SEL_W(4)) uut (
        .clk(clk), .rst(rst), .start(start), .abcd_in(abcd_in),
        .msg_in(msg_in), .sel_in(sel_in), .busy(busy), .done(done),
        .abcd_out(abcd_out)
    );

    function automatic logic [31:0] rl(logic [31:0] x, int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [127:0] ref4(logic [127:0] s, logic [127:0] m, logic [3:0] sel);
        logic [31:0] a, b, c, d, e, f, k, t, w;
        a = s[127:96]; b = s[95:64]; c = s[63:32]; d = s[31:0]; e = 0;
        for (int r = 0; r < 4; r++) begin
            w = m[127 - 32*r -: 32];
            case (sel[1:0])
                2'd0: begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
                2'd1: begin f = b ^ c ^ d;                    k = 32'h6ED9EBA1; end
                2'd2: begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
                default: begin f = b ^ c ^ d;                 k = 32'hCA62C1D6; end
            endcase
            t = f + rl(a, 5) + w + k + e;
            e = d; d = c; c = rl(b, 30); b = a; a = t;
        end
        return {a, b, c, d};
    endfunction

    function automatic logic [31:0] nxt(logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        return y ^ (y << 5);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Runs one operation; optionally raises start again while busy with other operands.
    task automatic run(input logic [127:0] s, input logic [127:0] m, input logic [3:0] sel,
                       input bit poke, input string tag);
        logic [127:0] exp;
        exp = ref4(s, m, sel);
        @(negedge clk);
        abcd_in = s; msg_in = m; sel_in = sel; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R7 busy after accept", 128'(busy), 128'(1));
        if (poke) begin
            abcd_in = ~s; msg_in = m ^ 128'hFFFF; sel_in = sel + 4'd1; start = 1'b1;
        end
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            if (i == 2) start = 1'b0;
            chk(done === (i == 4), "R8 done timing", 128'(done), 128'(i == 4));
        end
        chk(busy === 1'b0, "R8 busy falls with done", 128'(busy), 128'(0));
        chk(abcd_out === exp, tag, abcd_out, exp);
        @(negedge clk);
        chk(done === 1'b0, "R8 done one cycle", 128'(done), 128'(0));
        chk(abcd_out === exp, "R9 hold", abcd_out, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R10 reset state", {busy, done}, 128'(0));

        // R1 R2 R4 R5: zero and all-one operands exercise wraparound
        run('0, '0, 4'd0, 0, "R4 zero operands");
        run('1, '1, 4'd2, 0, "R4 all-one operands");
        run({32'h67452301, 32'hEFCDAB89, 32'h98BADCFE, 32'h10325476},
            {32'h61626380 + 32'hC3D2E1F0, 96'h0}, 4'd0, 0, "R1 R2 standard initial state");

        // R3 R6: every selector code including high bits, several operand sets
        for (int v = 0; v < 8; v++) begin
            logic [127:0] s, m;
            for (int j = 0; j < 4; j++) begin
                rng = nxt(rng); s[32*j +: 32] = rng;
                rng = nxt(rng); m[32*j +: 32] = rng;
            end
            for (int sc = 0; sc < 16; sc++)
                run(s, m, 4'(sc), 0, sc > 3 ? "R6 high selector bits ignored" : "R3 selector result");
        end

        // R7: start while busy ignored
        run({32'h01234567, 32'h89ABCDEF, 32'hFEDCBA98, 32'h76543210},
            {32'h0F0F0F0F, 32'hF0F0F0F0, 32'h33333333, 32'hCCCCCCCC}, 4'd1, 1, "R7 start while busy ignored");

        // R9: result held over idle cycles
        begin
            logic [127:0] held;
            held = abcd_out;
            repeat (5) @(negedge clk);
            chk(abcd_out === held, "R9 hold over idle", abcd_out, held);
        end

        // R10: reset mid-run then a clean run with correct latency
        @(negedge clk);
        abcd_in = '1; msg_in = '0; sel_in = 4'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(busy === 1'b0 && done === 1'b0, "R10 reset mid-run", {busy, done}, 128'(0));
        run({4{32'hA5A5A5A5}}, {4{32'h5A5A5A5A}}, 4'd3, 0, "R10 run after reset");

        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule